// File: doc/BRIEF.md
# Debug Return Controller

This block holds a processor's debug-mode state and acts on the debug-return instruction. It keeps three pieces of state: a flag that marks debug mode, a flag that suppresses imprecise error reporting, and the saved program counter to return to. A debug-exception entry strobe sets the debug flag and captures the interrupted PC. A coprocessor-0 write port lets software overwrite the saved PC or the inhibit flag.

Each valid instruction word is decoded for the debug-return encoding. In debug mode, outside a delay slot, a return clears both flags. It redirects fetch to the saved PC and squashes the next sequential instruction, because the return has no delay slot. A return outside debug mode raises a coprocessor-unusable trap for coprocessor 0 when the core is in user mode with the coprocessor-0 usable bit clear. Every other misuse is reported on an undefined-operation flag, and the state does not change.

All result outputs are registered. They appear in the cycle after the instruction is sampled.

Top module: `dbg_return_ctrl`

## Requirements
- R1: The instruction is a debug return only when bits 31:26 are 010000, bit 25 is 1, bits 24:6 are all zero and bits 5:0 are 011111 (32'h4200001F). Any other word produces no redirect, no trap and no undefined flag.
- R2: A return sampled in debug mode, not in a delay slot, causes the following effects one cycle later: redirectValid is 1, redirectPc equals the saved return PC, debugMode is 0 and ierrInhibit is 0.
- R3: squashNext is 1 in exactly the cycles where redirectValid is 1.
- R4: A return sampled outside debug mode with userMode=1 and cu0Usable=0 pulses cpUnusable with cpUnusableNum=0. This happens whether or not the return is in a delay slot. There is no redirect and no state change.
- R5: A return sampled outside debug mode in any other case pulses undefOp, with no redirect and no trap.
- R6: A return sampled in debug mode with inDelaySlot=1 pulses undefOp and makes no state change. debugMode and ierrInhibit keep their values, and there is no redirect.
- R7: A coprocessor-0 write with cp0WrSel=0 replaces the saved return PC, and a later return uses the new value. A write with cp0WrSel=1 loads ierrInhibit from cp0WrData bit 0. Both take effect from the next cycle.
- R8: dbgEntry sets debugMode and captures dbgEntryPc as the saved return PC at the same clock edge.
- R9: Reset (rstN low) clears debugMode and ierrInhibit, and all result outputs read 0.
- R10: redirectValid, cpUnusable and undefOp are one-cycle pulses. At most one of them is high in a cycle, and they rise only for a word sampled with instrValid=1. A return word sampled with instrValid=0 has no effect.
- R11: When dbgEntry and a return arrive in the same cycle, the entry wins. The return produces no output, debugMode stays 1, and the saved PC is the entry PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word to decode |
| inDelaySlot | input | 1 | Instruction sits in a branch or jump delay slot |
| userMode | input | 1 | Core is in user mode |
| cu0Usable | input | 1 | Coprocessor-0 usable bit |
| dbgEntry | input | 1 | Debug exception entry strobe |
| dbgEntryPc | input | ADDR_W | PC captured on debug entry |
| cp0WrEn | input | 1 | Coprocessor-0 write strobe |
| cp0WrSel | input | 1 | 0: saved return PC, 1: inhibit flag |
| cp0WrData | input | ADDR_W | Coprocessor-0 write data |
| redirectValid | output | 1 | Fetch redirect pulse |
| redirectPc | output | ADDR_W | Redirect target |
| squashNext | output | 1 | Kill the next sequential instruction |
| cpUnusable | output | 1 | Coprocessor-unusable trap pulse |
| cpUnusableNum | output | 2 | Coprocessor number of the trap |
| undefOp | output | 1 | Undefined-operation pulse |
| debugMode | output | 1 | Debug-mode flag |
| ierrInhibit | output | 1 | Imprecise-error inhibit flag |

## Verification
Every result is due one clock after the edge that samples its stimulus. The pulses and the redirect target come from output registers. debugMode, ierrInhibit and the saved PC update at that same edge. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and samples all outputs on the next falling edge. It then checks one further cycle to confirm that each pulse has dropped. State that is not visible directly, such as the saved PC, is read out through a later legal return.

// File: rtl/dbg_ret_pkg.sv
package dbg_ret_pkg;
  localparam logic [5:0] OPC_COP0 = 6'b010000;
  localparam logic [5:0] FN_DRET  = 6'b011111;
  localparam int         MID_W    = 19;

  typedef struct packed {
    logic enterDbg;
    logic leaveDbg;
    logic wrRetAddr;
    logic wrInhibit;
  } dpStrobes_t;
endpackage

// File: rtl/dbg_ret_decode.sv
module dbg_ret_decode
  import dbg_ret_pkg::*;
(
  input  logic [31:0] instrWord,
  output logic        isReturn
);
  logic opcHit;
  logic coHit;
  logic midZero;
  logic fnHit;

  always_comb begin
    opcHit   = (instrWord[31:26] == OPC_COP0);
    coHit    = instrWord[25];
    midZero  = (instrWord[24:6] == '0);
    fnHit    = (instrWord[5:0] == FN_DRET);
    isReturn = opcHit && coHit && midZero && fnHit;
  end
endmodule

// File: rtl/dbg_ret_datapath.sv
module dbg_ret_datapath
  import dbg_ret_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] entryPc,
  input  logic [ADDR_W-1:0] wrData,
  output logic              debugMode,
  output logic              ierrInhibit,
  output logic [ADDR_W-1:0] savedPc
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      debugMode   <= 1'b0;
      ierrInhibit <= 1'b0;
      savedPc     <= '0;
    end else begin
      if (strobes.enterDbg) begin
        debugMode <= 1'b1;
        savedPc   <= entryPc;
      end else begin
        if (strobes.leaveDbg) debugMode <= 1'b0;
        if (strobes.wrRetAddr) savedPc <= wrData;
      end
      if (strobes.leaveDbg) ierrInhibit <= 1'b0;
      else if (strobes.wrInhibit) ierrInhibit <= wrData[0];
    end
  end

  // R8
  entry_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterDbg |=> (debugMode && savedPc == $past(entryPc)));
endmodule

// File: rtl/dbg_ret_ctrl.sv
module dbg_ret_ctrl
  import dbg_ret_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic              isReturn,
  input  logic              inDelaySlot,
  input  logic              userMode,
  input  logic              cu0Usable,
  input  logic              dbgEntry,
  input  logic              cp0WrEn,
  input  logic              cp0WrSel,
  input  logic              debugMode,
  input  logic [ADDR_W-1:0] savedPc,
  output dpStrobes_t        strobes,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              squashNext,
  output logic              cpUnusable,
  output logic [1:0]        cpUnusableNum,
  output logic              undefOp
);
  logic retHit;
  logic legalRet;
  logic slotUndef;
  logic trapRet;
  logic plainUndef;

  always_comb begin
    retHit     = instrValid && isReturn && !dbgEntry;
    legalRet   = retHit && debugMode && !inDelaySlot;
    slotUndef  = retHit && debugMode && inDelaySlot;
    trapRet    = retHit && !debugMode && userMode && !cu0Usable;
    plainUndef = retHit && !debugMode && !trapRet;

    strobes.enterDbg  = dbgEntry;
    strobes.leaveDbg  = legalRet;
    strobes.wrRetAddr = cp0WrEn && !cp0WrSel;
    strobes.wrInhibit = cp0WrEn && cp0WrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      squashNext    <= 1'b0;
      cpUnusable    <= 1'b0;
      cpUnusableNum <= 2'd0;
      undefOp       <= 1'b0;
    end else begin
      redirectValid <= legalRet;
      squashNext    <= legalRet;
      if (legalRet) redirectPc <= savedPc;
      cpUnusable    <= trapRet;
      cpUnusableNum <= 2'd0;
      undefOp       <= slotUndef || plainUndef;
    end
  end

  // R10
  pulse_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redirectValid || cpUnusable || undefOp) |-> $past(instrValid));

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({redirectValid, cpUnusable, undefOp}));

  // R2
  redirect_leaves_dbg_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> !debugMode);

  // R4
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpUnusable |-> ($past(!debugMode && userMode && !cu0Usable) && !debugMode));

  // R6
  slot_keeps_dbg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotUndef && !cp0WrEn) |=> debugMode);
endmodule

// File: rtl/dbg_return_ctrl.sv
module dbg_return_ctrl
  import dbg_ret_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  input  logic              inDelaySlot,
  input  logic              userMode,
  input  logic              cu0Usable,
  input  logic              dbgEntry,
  input  logic [ADDR_W-1:0] dbgEntryPc,
  input  logic              cp0WrEn,
  input  logic              cp0WrSel,
  input  logic [ADDR_W-1:0] cp0WrData,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic              squashNext,
  output logic              cpUnusable,
  output logic [1:0]        cpUnusableNum,
  output logic              undefOp,
  output logic              debugMode,
  output logic              ierrInhibit
);
  logic              isReturn;
  dpStrobes_t        strobes;
  logic [ADDR_W-1:0] savedPc;

  dbg_ret_decode decode_i (
    .instrWord (instrWord),
    .isReturn  (isReturn)
  );

  dbg_ret_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .instrValid    (instrValid),
    .isReturn      (isReturn),
    .inDelaySlot   (inDelaySlot),
    .userMode      (userMode),
    .cu0Usable     (cu0Usable),
    .dbgEntry      (dbgEntry),
    .cp0WrEn       (cp0WrEn),
    .cp0WrSel      (cp0WrSel),
    .debugMode     (debugMode),
    .savedPc       (savedPc),
    .strobes       (strobes),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .squashNext    (squashNext),
    .cpUnusable    (cpUnusable),
    .cpUnusableNum (cpUnusableNum),
    .undefOp       (undefOp)
  );

  dbg_ret_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .entryPc     (dbgEntryPc),
    .wrData      (cp0WrData),
    .debugMode   (debugMode),
    .ierrInhibit (ierrInhibit),
    .savedPc     (savedPc)
  );
endmodule

// File: tb/dbg_return_ctrl_tb.sv
module dbg_return_ctrl_tb_top;
  localparam logic [31:0] RET = 32'h4200001F;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        inDelaySlot = 1'b0;
  logic        userMode = 1'b0;
  logic        cu0Usable = 1'b1;
  logic        dbgEntry = 1'b0;
  logic [31:0] dbgEntryPc = '0;
  logic        cp0WrEn = 1'b0;
  logic        cp0WrSel = 1'b0;
  logic [31:0] cp0WrData = '0;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        squashNext;
  logic        cpUnusable;
  logic [1:0]  cpUnusableNum;
  logic        undefOp;
  logic        debugMode;
  logic        ierrInhibit;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dbg_return_ctrl dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .inDelaySlot(inDelaySlot), .userMode(userMode), .cu0Usable(cu0Usable),
    .dbgEntry(dbgEntry), .dbgEntryPc(dbgEntryPc), .cp0WrEn(cp0WrEn),
    .cp0WrSel(cp0WrSel), .cp0WrData(cp0WrData), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .squashNext(squashNext), .cpUnusable(cpUnusable),
    .cpUnusableNum(cpUnusableNum), .undefOp(undefOp), .debugMode(debugMode),
    .ierrInhibit(ierrInhibit)
  );

  typedef struct packed {
    logic        inDbg;
    logic        user;
    logic        cu0;
    logic        slot;
    logic [31:0] word;
    logic        expRed;
    logic        expCpu;
    logic        expUnd;
    logic        expDbg;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b0, RET,          1'b1, 1'b0, 1'b0, 1'b0}, // R2 legal
    '{1'b1, 1'b0, 1'b1, 1'b1, RET,          1'b0, 1'b0, 1'b1, 1'b1}, // R6 slot
    '{1'b0, 1'b1, 1'b0, 1'b0, RET,          1'b0, 1'b1, 1'b0, 1'b0}, // R4 trap
    '{1'b0, 1'b1, 1'b1, 1'b0, RET,          1'b0, 1'b0, 1'b1, 1'b0}, // R5 user cu0
    '{1'b0, 1'b0, 1'b0, 1'b0, RET,          1'b0, 1'b0, 1'b1, 1'b0}, // R5 kernel
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h4200001E, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 func
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h4200005F, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 mid
    '{1'b1, 1'b1, 1'b0, 1'b0, RET,          1'b1, 1'b0, 1'b0, 1'b0}, // R2 user bits ignored
    '{1'b0, 1'b1, 1'b0, 1'b1, RET,          1'b0, 1'b1, 1'b0, 1'b0}, // R4 slot
    '{1'b1, 1'b0, 1'b1, 1'b0, 32'h4000001F, 1'b0, 1'b0, 1'b0, 1'b1}  // R1 co bit
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doInstr(input logic [31:0] w, input logic slot, input logic usr,
                         input logic cu0, input logic vld);
    @(negedge clk);
    instrValid = vld; instrWord = w; inDelaySlot = slot;
    userMode = usr; cu0Usable = cu0;
    @(negedge clk);
    instrValid = 1'b0; instrWord = '0; inDelaySlot = 1'b0;
  endtask

  task automatic enterDbg(input logic [31:0] pc);
    @(negedge clk);
    dbgEntry = 1'b1; dbgEntryPc = pc;
    @(negedge clk);
    dbgEntry = 1'b0;
  endtask

  task automatic cp0Write(input logic sel, input logic [31:0] d);
    @(negedge clk);
    cp0WrEn = 1'b1; cp0WrSel = sel; cp0WrData = d;
    @(negedge clk);
    cp0WrEn = 1'b0;
  endtask

  task automatic checkIdle(input string req);
    chk(req, {29'd0, redirectValid, cpUnusable, undefOp}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 flags", {30'd0, debugMode, ierrInhibit}, 32'd0);
    chk("R9 outputs", {28'd0, redirectValid, squashNext, cpUnusable, undefOp}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].inDbg) enterDbg(32'h1000 + 32'(i) * 32'h10);
      else if (debugMode) doInstr(RET, 1'b0, 1'b0, 1'b1, 1'b1);
      doInstr(VECS[i].word, VECS[i].slot, VECS[i].user, VECS[i].cu0, 1'b1);
      chk("R1/R2 redirect", {31'd0, redirectValid}, {31'd0, VECS[i].expRed});
      chk("R3 squash", {31'd0, squashNext}, {31'd0, VECS[i].expRed});
      chk("R4 trap", {31'd0, cpUnusable}, {31'd0, VECS[i].expCpu});
      chk("R5/R6 undef", {31'd0, undefOp}, {31'd0, VECS[i].expUnd});
      chk("R2/R6 debugMode", {31'd0, debugMode}, {31'd0, VECS[i].expDbg});
      if (VECS[i].expRed) chk("R2 target", redirectPc, 32'h1000 + 32'(i) * 32'h10);
      if (VECS[i].expCpu) chk("R4 cop num", {30'd0, cpUnusableNum}, 32'd0);
      @(negedge clk);
      checkIdle("R10 single pulse");
    end

    // R7 saved PC rewrite, R2 inhibit cleared
    enterDbg(32'h2000);
    cp0Write(1'b0, 32'hABCD_0040);
    cp0Write(1'b1, 32'h1);
    chk("R7 inhibit set", {31'd0, ierrInhibit}, 32'd1);
    doInstr(RET, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R7 written target", redirectPc, 32'hABCD_0040);
    chk("R2 inhibit cleared", {30'd0, debugMode, ierrInhibit}, 32'd0);

    // R6 slot keeps inhibit
    enterDbg(32'h3000);
    cp0Write(1'b1, 32'h1);
    doInstr(RET, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R6 state kept", {30'd0, debugMode, ierrInhibit}, 32'd3);
    chk("R6 no redirect", {31'd0, redirectValid}, 32'd0);

    // R10 return with valid low ignored
    doInstr(RET, 1'b0, 1'b0, 1'b1, 1'b0);
    checkIdle("R10 valid low");
    chk("R10 state kept", {31'd0, debugMode}, 32'd1);

    // R11 entry beats return
    @(negedge clk);
    dbgEntry = 1'b1; dbgEntryPc = 32'h5550; instrValid = 1'b1; instrWord = RET;
    @(negedge clk);
    dbgEntry = 1'b0; instrValid = 1'b0;
    checkIdle("R11 no output");
    chk("R11 debugMode", {31'd0, debugMode}, 32'd1);
    doInstr(RET, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R11 saved entry pc", redirectPc, 32'h5550);

    // R8 entry capture read back through return
    enterDbg(32'h7770);
    chk("R8 debug set", {31'd0, debugMode}, 32'd1);
    doInstr(RET, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R8 captured pc", redirectPc, 32'h7770);

    // R9 reset in debug mode
    enterDbg(32'h8000);
    cp0Write(1'b1, 32'h1);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 mid-run reset", {30'd0, debugMode, ierrInhibit}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule